// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external byte-wide asynchronous static RAM with 20 address bits. The host issues one read or one write at a time over a valid/ready handshake. The controller latches the request and then drives the RAM's address, two chip selects of opposite polarity, write strobe and output enable through a fixed sequence of phases. It also drives the outgoing data bus and that bus's tristate enable. A completion pulse marks the end of each request, and a read also returns the byte it fetched.

Every timing minimum is a parameter in nanoseconds, as is the clock period. Each phase lasts the rounded-up number of whole clock cycles that covers its minimum, and never less than one cycle. The controller tracks how long the RAM's output enable has been released. A write that follows a read closely therefore waits out the RAM's release interval before the controller turns its own drivers on. When no request is pending, the RAM is deselected and held in standby.

Top module: `sram_cycle_ctl`

## Requirements
- R1: While idle and out of reset, the active-low chip select, the write strobe and the output enable are all high, the data drivers are off, and ready is high. The active-high chip select is low during reset and high from the first cycle after reset.
- R2: A read holds the active-low chip select low and the output enable low, with the write strobe high and the drivers off, for RD_CYC cycles. RD_CYC is the largest of the rounded-up cycle counts for the cycle time, address-to-data time and enable-to-data time (3 cycles at a 20 ns clock).
- R3: The byte on the RAM data input during the last read cycle is returned on the read data output together with the completion pulse.
- R4: A write holds the strobe low for WR_PULSE cycles, with the chip select low and the drivers on. WR_PULSE is the largest of the rounded-up counts for strobe width, address setup and data setup (2 cycles at a 20 ns clock).
- R5: The strobe rises while the chip select is still low, and the drivers stay on for max(1, cycle-time cycles − WR_PULSE) hold cycles after it (1 at a 20 ns clock).
- R6: The data drivers turn on only after the output enable has been high for HZ_CYC complete cycles, where HZ_CYC is the rounded-up release time. A write with fewer quiet cycles behind it inserts turnaround cycles, during which the chip select is low and the strobe, output enable and drivers are all off.
- R7: The completion output is high for exactly one cycle per request, in the cycle after that request's last phase.
- R8: Ready is high only when idle. Address and write data are taken at acceptance, and the RAM address stays constant for the whole access even if the host inputs change.
- R9: The output enable stays high for the whole of a write, including turnaround and hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Request byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Captured read data |
| sram_addr_o | output | 20 | RAM address |
| sram_dq_o | output | 8 | Data toward the RAM |
| sram_dq_oe_o | output | 1 | Tristate enable for sram_dq_o |
| sram_dq_i | input | 8 | Data from the RAM pins |
| sram_ce_n_o | output | 1 | Active-low chip select |
| sram_ce_o | output | 1 | Active-high chip select |
| sram_we_n_o | output | 1 | Active-low write strobe |
| sram_oe_n_o | output | 1 | Active-low output enable |

## Verification
The hardest case to reach is a write that arrives while the output enable has been released for fewer than HZ_CYC cycles. At the default release time one idle cycle already covers the interval. The bench therefore raises the release time to 50 ns, so HZ_CYC is 3. It then issues a write in the very cycle the preceding read reports completion, which needs two turnaround cycles. A second write comes after a two-cycle gap and needs none. The bench keeps its own count of quiet output-enable cycles and flags any cycle in which the drivers are on too early.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WPULSE,
    ST_WHOLD
  } ctl_state_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  a_r2_timer_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sram_bus_quiet.sv
// Counts complete cycles with output enable released, saturating at HZ_CYC.
module sram_bus_quiet #(
  parameter int unsigned HZ_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_n_i,
  output logic quiet_o,
  output logic quiet_next_o
);
  localparam int unsigned QW = $clog2(HZ_CYC + 1) + 1;
  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= QW'(HZ_CYC);
    else if (!oe_n_i)              cnt_q <= '0;
    else if (!quiet_o)             cnt_q <= cnt_q + 1'b1;
  end

  assign quiet_o      = (int'(cnt_q) >= int'(HZ_CYC));
  assign quiet_next_o = oe_n_i && ((int'(cnt_q) + 1) >= int'(HZ_CYC));

  a_r6_quiet_cleared_by_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_i |=> !quiet_o);
endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS    = 20,
  parameter int unsigned T_CYCLE_NS       = 45,
  parameter int unsigned T_ADDR_DATA_NS   = 45,
  parameter int unsigned T_OE_DATA_NS     = 22,
  parameter int unsigned T_WE_PULSE_NS    = 35,
  parameter int unsigned T_ADDR_SETUP_NS  = 35,
  parameter int unsigned T_DATA_SETUP_NS  = 25,
  parameter int unsigned T_OE_RELEASE_NS  = 18,
  parameter int unsigned AW               = 20,
  parameter int unsigned DW               = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_ce_n_o,
  output logic          sram_ce_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o
);
  localparam int unsigned CYC_WC   = ns2cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC   = max3(CYC_WC, ns2cyc(T_ADDR_DATA_NS, CLK_PERIOD_NS),
                                          ns2cyc(T_OE_DATA_NS, CLK_PERIOD_NS));
  localparam int unsigned WR_PULSE = max3(ns2cyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                          ns2cyc(T_ADDR_SETUP_NS, CLK_PERIOD_NS),
                                          ns2cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int unsigned WR_HOLD  = (CYC_WC > WR_PULSE + 1) ? (CYC_WC - WR_PULSE) : 1;
  localparam int unsigned HZ_CYC   = ns2cyc(T_OE_RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned MAXC     = max3(RD_CYC, WR_PULSE, WR_HOLD);
  localparam int unsigned CW       = $clog2(MAXC + 1);

  ctl_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q, ce_q;
  logic          tmr_load, tmr_last;
  logic [CW-1:0] tmr_len;
  logic          quiet, quiet_next;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = CW'(RD_CYC);
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (!req_write_i) begin
          state_d = ST_READ; tmr_load = 1'b1; tmr_len = CW'(RD_CYC);
        end else if (quiet_next) begin
          state_d = ST_WPULSE; tmr_load = 1'b1; tmr_len = CW'(WR_PULSE);
        end else begin
          state_d = ST_TURN;
        end
      end
      ST_READ:   if (tmr_last) state_d = ST_IDLE;
      ST_TURN:   if (quiet_next) begin
        state_d = ST_WPULSE; tmr_load = 1'b1; tmr_len = CW'(WR_PULSE);
      end
      ST_WPULSE: if (tmr_last) begin
        state_d = ST_WHOLD; tmr_load = 1'b1; tmr_len = CW'(WR_HOLD);
      end
      ST_WHOLD:  if (tmr_last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      ce_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= 1'b1;
      done_q  <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (state_q == ST_READ && tmr_last) begin
        rdata_q <= sram_dq_i;
        done_q  <= 1'b1;
      end
      if (state_q == ST_WHOLD && tmr_last) done_q <= 1'b1;
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  sram_bus_quiet #(.HZ_CYC(HZ_CYC)) u_quiet (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oe_n_i       (sram_oe_n_o),
    .quiet_o      (quiet),
    .quiet_next_o (quiet_next)
  );

  assign req_ready_o  = (state_q == ST_IDLE);
  assign sram_ce_n_o  = (state_q == ST_IDLE);
  assign sram_ce_o    = ce_q;
  assign sram_oe_n_o  = (state_q != ST_READ);
  assign sram_we_n_o  = (state_q != ST_WPULSE);
  assign sram_dq_oe_o = (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign rsp_done_o   = done_q;
  assign rsp_rdata_o  = rdata_q;

  a_r6_drive_only_when_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> quiet);
  a_r9_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o || sram_dq_oe_o) |-> sram_oe_n_o);
  a_r5_strobe_ends_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (!sram_ce_n_o && sram_dq_oe_o));
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_n_o && $past(!sram_ce_n_o)) |-> $stable(sram_addr_o));
  a_r8_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> !req_ready_o);
endmodule

// File: tb/sram_cycle_ctl_test.sv
module sram_cycle_ctl_test;
  localparam int HZ_B  = 3;  // ceil(50/20)
  localparam int RD_B  = 3;  // ceil(max(45,45,22)/20)
  localparam int WP_B  = 2;  // ceil(max(35,35,25)/20)
  localparam int WH_B  = 1;  // max(1, 3-2)

  typedef struct packed {
    logic        wr;
    logic [19:0] addr;
    logic [7:0]  data;
    logic [3:0]  gap;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 20'h00010, 8'hA5, 4'd0},
    '{1'b1, 20'hFFFFF, 8'h3C, 4'd0},
    '{1'b0, 20'h00010, 8'h00, 4'd0},
    '{1'b1, 20'h12345, 8'h77, 4'd0},
    '{1'b0, 20'hFFFFF, 8'h00, 4'd0},
    '{1'b0, 20'h12345, 8'h00, 4'd2},
    '{1'b1, 20'h00010, 8'h5A, 4'd2},
    '{1'b0, 20'h00010, 8'h00, 4'd0}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done, dq_oe, ce_n, ce, we_n, oe_n;
  logic [7:0] rsp_rdata, dq_o, dq_i;
  logic [19:0] s_addr;

  logic [7:0] model [1024];
  logic [7:0] refm  [1024];

  int checks = 0, errors = 0, quiet = 100;
  bit prev_done = 0, finished = 0;

  always #10 clk = ~clk;

  sram_cycle_ctl #(.T_OE_RELEASE_NS(50)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(s_addr), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i),
    .sram_ce_n_o(ce_n), .sram_ce_o(ce), .sram_we_n_o(we_n), .sram_oe_n_o(oe_n)
  );

  // RAM model
  assign dq_i = (!ce_n && ce && !oe_n && we_n) ? model[s_addr[9:0]] : 8'h00;
  always @(posedge clk) if (!ce_n && ce && !we_n && dq_oe) model[s_addr[9:0]] <= dq_o;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst_n) return;
    if (!oe_n) quiet = 0; else quiet++;
    if (dq_oe) check(quiet >= HZ_B + 1, "R6 drivers on before release", quiet, HZ_B + 1);
    if (prev_done) check(!rsp_done, "R7 done width", rsp_done, 0);
    if (req_ready)
      check(ce_n && we_n && oe_n && !dq_oe && ce, "R1 idle standby",
            {ce_n, ce, we_n, oe_n, dq_oe}, 5'b11110);
    prev_done = rsp_done;
  endtask

  task automatic do_req(input vec_t v);
    int oe_low = 0, we_low = 0, ta = 0, hold = 0, cyc = 0, exp_ta;
    repeat (v.gap) step();
    exp_ta = v.wr ? ((HZ_B - quiet > 0) ? HZ_B - quiet : 0) : 0;
    check(req_ready, "R8 ready when idle", req_ready, 1);
    req_valid = 1; req_write = v.wr; req_addr = v.addr; req_wdata = v.data;
    step();
    req_valid = 0; req_addr = ~v.addr; req_wdata = ~v.data;
    while (!rsp_done && cyc < 50) begin
      cyc++;
      if (req_ready) check(0, "R8 ready while busy", 1, 0);
      if (s_addr != v.addr) check(0, "R8 address held", s_addr, v.addr);
      if (!oe_n) oe_low++;
      if (!we_n) begin
        we_low++;
        if (ce_n || !dq_oe || dq_o != v.data)
          check(0, "R4 strobe phase", {ce_n, dq_oe, dq_o}, {1'b0, 1'b1, v.data});
      end
      if (!ce_n && we_n && oe_n && !dq_oe) ta++;
      if (!ce_n && we_n && dq_oe) hold++;
      if (!oe_n && (!we_n || dq_oe)) check(0, "R2 read phase", {we_n, dq_oe}, 2'b10);
      step();
    end
    check(rsp_done, "R7 done arrives", rsp_done, 1);
    if (v.wr) begin
      refm[v.addr[9:0]] = v.data;
      check(we_low == WP_B, "R4 strobe cycles", we_low, WP_B);
      check(hold == WH_B, "R5 hold cycles", hold, WH_B);
      check(ta == exp_ta, "R6 turnaround cycles", ta, exp_ta);
      check(oe_low == 0, "R9 oe during write", oe_low, 0);
      check(cyc == exp_ta + WP_B + WH_B, "R4 write length", cyc, exp_ta + WP_B + WH_B);
    end else begin
      check(oe_low == RD_B, "R2 read cycles", oe_low, RD_B);
      check(cyc == RD_B, "R2 read length", cyc, RD_B);
      check(rsp_rdata == refm[v.addr[9:0]], "R3 read data", rsp_rdata, refm[v.addr[9:0]]);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin model[i] = 8'h00; refm[i] = 8'h00; end
    @(negedge clk);
    check(ce_n && !ce && we_n && oe_n && !dq_oe && !rsp_done, "R1 reset state",
          {ce_n, ce, we_n, oe_n, dq_oe, rsp_done}, 6'b101100);
    @(negedge clk);
    rst_n = 1;
    step();
    check(ce && ce_n && req_ready, "R1 select after reset", {ce, ce_n, req_ready}, 3'b111);
    for (int i = 0; i < 8; i++) do_req(VECS[i]);
    // R6: back-to-back read then write to a fresh address
    do_req('{1'b0, 20'h00200, 8'h00, 4'd0});
    do_req('{1'b1, 20'h00200, 8'hC3, 4'd0});
    // R6: one idle cycle after a read leaves one turnaround cycle
    do_req('{1'b0, 20'h00200, 8'h00, 4'd0});
    do_req('{1'b1, 20'h00201, 8'h0F, 4'd1});
    do_req('{1'b0, 20'h00201, 8'h00, 4'd3});
    // R1: long idle keeps standby
    repeat (5) step();
    check(!dq_oe && ce_n, "R1 standby after idle", {dq_oe, ce_n}, 2'b01);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule